// File: doc/BRIEF.md
# Sticky LED Fault Status Register

This block collects fault indications from the monitors of an LED matrix driver and holds them in a readable status byte. There are three fault sources. Per-lane open-circuit and short-circuit detectors are only believed while their lane is actually being driven. A chip-wide overtemperature sensor is not qualified. Each source sets its own flag, and each flag stays set until software clears it. A fourth bit reports whether any of the three flags is set.

Software reads the byte through a read strobe. The byte is captured one cycle later and held until the next read. Reading never disturbs the flags. Clearing is done with a write strobe, and no data value is involved: a local write clears everything. A broadcast write, which reaches every device sharing the control bus, clears everything in the same way. The upper nibble of the byte is a fixed device identifier set by parameter.

Top module: `led_fault_status`

## Requirements
- R1: After reset all flags are 0, and rd_data reads {DEV_ID, 4'b0000} until the first read.
- R2: The open flag (status bit 0) sets in the cycle after any lane has open_det and led_on both high, and stays set while no clear occurs.
- R3: The short flag (status bit 1) sets in the cycle after any lane has short_det and led_on both high, and stays set while no clear occurs.
- R4: open_det and short_det on a lane whose led_on is low have no effect on any flag.
- R5: The overtemperature flag (status bit 2) sets in the cycle after ot_det is high, regardless of led_on.
- R6: Status bit 3 equals the OR of bits 0, 1 and 2.
- R7: A read strobe loads rd_data with {DEV_ID[3:0], any, ot, short, open} one cycle later. rd_data holds between reads, and a read clears no flag.
- R8: A local write strobe (reg_wr) clears all three flags in the next cycle.
- R9: A broadcast write strobe (reg_wr_bcast) clears all three flags exactly as a local write does.
- R10: A fault event in the same cycle as a clearing write leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| led_on | input | N_LANES | Lane currently driven on |
| open_det | input | N_LANES | Open-circuit detector per lane |
| short_det | input | N_LANES | Short-circuit detector per lane |
| ot_det | input | 1 | Overtemperature detector |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Local write strobe (clears flags) |
| reg_wr_bcast | input | 1 | Broadcast write strobe (clears flags) |
| rd_data | output | 8 | Captured status byte |

## Verification
The bench builds the block with three lanes and a device identifier of 0x5. Three lanes are enough for random detector patterns to hit the case where one lane is lit and another is not in the same cycle. The non-default identifier shows that the upper nibble comes from the parameter. Random strobes collide often with events and with each other, so clear-versus-set priority and back-to-back reads are both reached. Directed cases cover reset, fully unlit detection, and each clear path.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;
  localparam int FLAG_OPEN  = 0;
  localparam int FLAG_SHORT = 1;
  localparam int FLAG_OT    = 2;
  localparam int FLAG_ANY   = 3;
  localparam int NUM_SRC    = 3;
  localparam int STAT_W     = 8;
  localparam int ID_W       = STAT_W - NUM_SRC - 1;

  // Assemble the status byte from the identifier and the three source flags.
  function automatic logic [STAT_W-1:0] pack_status(input logic [ID_W-1:0] id,
                                                    input logic [NUM_SRC-1:0] src);
    logic [STAT_W-1:0] b;
    b = '0;
    b[FLAG_OPEN]  = src[FLAG_OPEN];
    b[FLAG_SHORT] = src[FLAG_SHORT];
    b[FLAG_OT]    = src[FLAG_OT];
    b[FLAG_ANY]   = |src;
    b[STAT_W-1:FLAG_ANY+1] = id;
    return b;
  endfunction
endpackage

// File: rtl/fault_qualify.sv
module fault_qualify #(
  parameter int N_LANES = 4
) (
  input  logic [N_LANES-1:0] det,
  input  logic [N_LANES-1:0] lit,
  output logic               hit
);
  logic [N_LANES-1:0] gated;

  // A detector only counts while its lane is driven.
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    assign gated[i] = det[i] & lit[i];
  end

  assign hit = |gated;
endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= 1'b0;
    else if (set_ev) q <= 1'b1;   // event wins over clear
    else if (clr)    q <= 1'b0;
  end

  // R10: an event beats a simultaneous clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> q);
  // R8: a clear with no event empties the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_ev) |=> !q);
  // R2: a set flag stays set until cleared
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
endmodule

// File: rtl/led_fault_status.sv
module led_fault_status
  import led_fault_pkg::*;
#(
  parameter int              N_LANES = 4,
  parameter logic [ID_W-1:0] DEV_ID  = 4'hA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LANES-1:0] led_on,
  input  logic [N_LANES-1:0] open_det,
  input  logic [N_LANES-1:0] short_det,
  input  logic               ot_det,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic               reg_wr_bcast,
  output logic [STAT_W-1:0]  rd_data
);
  logic               open_hit;
  logic               short_hit;
  logic               clr_any;
  logic [NUM_SRC-1:0] src_ev;
  logic [NUM_SRC-1:0] flag_q;

  fault_qualify #(.N_LANES(N_LANES)) u_open_q (
    .det(open_det), .lit(led_on), .hit(open_hit));
  fault_qualify #(.N_LANES(N_LANES)) u_short_q (
    .det(short_det), .lit(led_on), .hit(short_hit));

  // Local and broadcast writes take the same clearing path.
  assign clr_any = reg_wr | reg_wr_bcast;

  always_comb begin
    src_ev             = '0;
    src_ev[FLAG_OPEN]  = open_hit;
    src_ev[FLAG_SHORT] = short_hit;
    src_ev[FLAG_OT]    = ot_det;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
    fault_latch u_latch (
      .clk(clk), .rst_n(rst_n), .set_ev(src_ev[k]), .clr(clr_any), .q(flag_q[k]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= pack_status(DEV_ID, '0);
    else if (reg_rd) rd_data <= pack_status(DEV_ID, flag_q);
  end

  // R4: the open flag can only rise after a lit lane reported open
  a_r4_open_lit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[FLAG_OPEN]) |-> $past(|(open_det & led_on)));
  // R4: the short flag can only rise after a lit lane reported short
  a_r4_short_lit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[FLAG_SHORT]) |-> $past(|(short_det & led_on)));
  // R9: a broadcast write with no event empties every flag
  a_r9_bcast_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_bcast && !open_hit && !short_hit && !ot_det) |=> (flag_q == '0));
  // R7: rd_data holds between reads
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(rd_data));
  // R6: the summary bit follows the captured flags
  a_r6_summary: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (rd_data[FLAG_ANY] == (|$past(flag_q))));
endmodule

// File: tb/led_fault_status_test.sv
`timescale 1ns/1ps
module led_fault_status_test;
  localparam int         NL  = 3;
  localparam logic [3:0] DID = 4'h5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] led_on = '0, open_det = '0, short_det = '0;
  logic          ot_det = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0, reg_wr_bcast = 1'b0;
  logic [7:0]    rd_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] m_flags = '0;      // model: {ot, short, open}
  logic [7:0] m_rd;

  always #2 clk = ~clk;

  led_fault_status #(.N_LANES(NL), .DEV_ID(DID)) uut (
    .clk(clk), .rst_n(rst_n), .led_on(led_on), .open_det(open_det),
    .short_det(short_det), .ot_det(ot_det), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wr_bcast(reg_wr_bcast), .rd_data(rd_data));

  function automatic logic [7:0] exp_byte(input logic [2:0] f);
    return {DID, (f[0] | f[1] | f[2]), f[2], f[1], f[0]};
  endfunction

  function automatic logic [2:0] next_flags(input logic [2:0] f);
    logic [2:0] ev;
    ev[0] = |(open_det & led_on);
    ev[1] = |(short_det & led_on);
    ev[2] = ot_det;
    return ev | ((reg_wr || reg_wr_bcast) ? 3'b000 : f);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected %h", tag, got, exp);
    end
  endtask

  // Advance one clock while keeping the model in step; compare at the falling edge.
  task automatic tick(input string tag);
    logic [2:0] nf;
    logic [7:0] nr;
    nf = next_flags(m_flags);
    nr = reg_rd ? exp_byte(m_flags) : m_rd;
    @(negedge clk);
    m_flags = nf;
    m_rd = nr;
    if (tag == "") begin
      chk("R2 open bit",  {7'd0, rd_data[0]}, {7'd0, m_rd[0]});
      chk("R3 short bit", {7'd0, rd_data[1]}, {7'd0, m_rd[1]});
      chk("R5 ot bit",    {7'd0, rd_data[2]}, {7'd0, m_rd[2]});
      chk("R6 summary",   {7'd0, rd_data[3]}, {7'd0, m_rd[3]});
      chk("R7 id/hold",   {4'd0, rd_data[7:4]}, {4'd0, m_rd[7:4]});
    end else begin
      chk(tag, rd_data, m_rd);
    end
  endtask

  task automatic idle();
    led_on = '0; open_det = '0; short_det = '0; ot_det = 0;
    reg_rd = 0; reg_wr = 0; reg_wr_bcast = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_rd = exp_byte(3'b000);
    repeat (3) @(negedge clk);
    chk("R1 reset value", rd_data, exp_byte(3'b000));
    rst_n = 1'b1;
    reg_rd = 1; tick("R1 read after reset"); idle();

    // R4: detectors on unlit lanes
    open_det = '1; short_det = '1; led_on = '0; tick("R4 unlit"); idle();
    reg_rd = 1; tick("R4 unlit read"); idle();

    // R2/R3 on one lit lane while others are unlit but asserting
    open_det = 3'b110; short_det = 3'b011; led_on = 3'b010; tick("R2 lit lane"); idle();
    reg_rd = 1; tick("R3 lit lane read"); idle();
    reg_rd = 1; tick("R7 read does not clear"); idle();

    // R8: local clear
    ot_det = 1; tick("R5 ot set"); idle();
    reg_wr = 1; tick("R8 local clear"); idle();
    reg_rd = 1; tick("R8 local clear read"); idle();

    // R9: broadcast clear
    ot_det = 1; open_det = 3'b001; led_on = 3'b001; tick("R5 set again"); idle();
    reg_wr_bcast = 1; tick("R9 bcast clear"); idle();
    reg_rd = 1; tick("R9 bcast clear read"); idle();

    // R10: event and clear in the same cycle
    short_det = 3'b100; led_on = 3'b100; ot_det = 1; tick("R10 pre"); idle();
    reg_wr = 1; ot_det = 1; tick("R10 collide"); idle();
    reg_rd = 1; tick("R10 collide read"); idle();

    for (int i = 0; i < 4000; i++) begin
      led_on       = NL'($urandom);
      open_det     = (($urandom % 6) == 0) ? NL'($urandom) : '0;
      short_det    = (($urandom % 6) == 0) ? NL'($urandom) : '0;
      ot_det       = (($urandom % 20) == 0);
      reg_rd       = (($urandom % 3) == 0);
      reg_wr       = (($urandom % 12) == 0);
      reg_wr_bcast = (($urandom % 12) == 0);
      tick("");
    end
    idle();
    reg_rd = 1; tick("R7 final read"); idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule